// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block sits on the controller side of an SDRAM interface and decides when an all-bank auto-refresh is owed. It counts controller clock cycles against a refresh interval derived from the clock period. Each time the interval runs out, one more refresh is owed. The interval is the normal 7.8 µs spacing while the case temperature is below 85 °C. When the `hot_band` input reports the extended band (85 °C to 95 °C), the spacing halves to 3.9 µs. The `hot_band` input is meant to be driven by the controller's mode-register bit that selects the extended-temperature rate.

Owed refreshes are held in a small debt ledger, so the command scheduler can postpone them while traffic is busy. The request and grant pair works as a valid/ready handshake. `refresh_req` stays high as long as at least one refresh is owed. A refresh is taken only in a cycle where `refresh_req` and `refresh_grant` are both high. The scheduler applies back-pressure by holding grant low. Grant has no effect while the request is low. Once the postponed count reaches its limit, `refresh_urgent` tells the scheduler to stop deferring.

Top module: `refresh_pacer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `refresh_req` and `refresh_urgent` are 0.
- R2: With `hot_band` low, one refresh becomes owed every N = floor(NORMAL_SPAN_PS / CLK_PERIOD_PS) clocks. After reset is released with no grant, `refresh_req` first reads 1 after exactly N rising edges.
- R3: With `hot_band` high, the interval is H = floor(HOT_SPAN_PS / CLK_PERIOD_PS) clocks. With the defaults this is half of N.
- R4: A change of `hot_band` does not restart the running interval. Let c be the number of clocks already counted when `hot_band` rises. The next expiry then occurs after max(H, c+1) clocks from the start of the interval.
- R5: `refresh_req` is 1 exactly while the owed count is nonzero. Each cycle with `refresh_req` and `refresh_grant` both high removes one owed refresh. Without such a cycle, the request stays high.
- R6: `refresh_grant` while `refresh_req` is low changes nothing.
- R7: A grant taken in the same cycle as an interval expiry leaves the owed count unchanged.
- R8: `refresh_urgent` is 1 exactly while the owed count equals MAX_DEBT (default 8).
- R9: The owed count never exceeds MAX_DEBT. An expiry at MAX_DEBT without a grant is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_band | input | 1 | 1 selects the extended-temperature (halved) refresh interval |
| refresh_grant | input | 1 | Ready: scheduler takes one refresh this cycle |
| refresh_req | output | 1 | Valid: at least one refresh is owed |
| refresh_urgent | output | 1 | Owed count has reached MAX_DEBT |

## Verification
The hardest case to reach is a temperature-band switch that lands after the running count has already passed the shorter interval. In that case the expiry must fire on the very next clock, not wrap around. The bench reaches it by counting clocks from reset release and raising `hot_band` at every offset within one normal interval. For each offset it compares the first request edge against max(H, c+1). It also aligns a single-cycle grant with a known expiry cycle to hit the simultaneous add-and-remove case.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // Whole clocks that fit in a time span, at least one.
  function automatic int unsigned interval_clocks(input int unsigned span_ps,
                                                  input int unsigned period_ps);
    int unsigned q;
    q = span_ps / period_ps;
    return (q < 1) ? 1 : q;
  endfunction
endpackage

// File: rtl/refi_timer.sv
module refi_timer #(
  parameter int LIM_NORMAL = 3120,
  parameter int LIM_HOT    = 1560,
  parameter int CW         = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  output logic tick
);
  localparam int LIM_MAX = (LIM_NORMAL > LIM_HOT) ? LIM_NORMAL : LIM_HOT;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  // The interval is picked on every cycle, so a band change affects the
  // running count without restarting it.
  assign last = hot ? CW'(LIM_HOT - 1) : CW'(LIM_NORMAL - 1);
  assign tick = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) < LIM_MAX));
  a_r4_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (cnt == $past(cnt) + CW'(1)));
endmodule

// File: rtl/debt_ledger.sv
module debt_ledger #(
  parameter int MAX_DEBT = 8,
  parameter int DW       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic grant,
  output logic req,
  output logic urgent
);
  logic [DW-1:0] debt;
  logic [DW-1:0] debt_nx;
  logic          take;
  logic          at_cap;

  assign at_cap = (debt == DW'(MAX_DEBT));
  assign req    = (debt != '0);
  assign urgent = at_cap;
  assign take   = req & grant;

  always_comb begin
    debt_nx = debt;
    if (tick && !take && !at_cap) debt_nx = debt + DW'(1);
    else if (take && !tick) debt_nx = debt - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt <= '0;
    else debt <= debt_nx;
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(debt) <= MAX_DEBT));
  a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !grant) |=> req);
  a_r8_urgent_implies_req: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);
  a_r7_pair_keeps_debt: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && req && grant) |=> $stable(debt));
  a_r6_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !tick) |=> !req);
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer #(
  parameter int CLK_PERIOD_PS  = 2500,
  parameter int NORMAL_SPAN_PS = 7_800_000,
  parameter int HOT_SPAN_PS    = 3_900_000,
  parameter int MAX_DEBT       = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_band,
  input  logic refresh_grant,
  output logic refresh_req,
  output logic refresh_urgent
);
  localparam int LIM_N = int'(refresh_pkg::interval_clocks(NORMAL_SPAN_PS, CLK_PERIOD_PS));
  localparam int LIM_H = int'(refresh_pkg::interval_clocks(HOT_SPAN_PS, CLK_PERIOD_PS));
  localparam int LIM_MAX = (LIM_N > LIM_H) ? LIM_N : LIM_H;
  localparam int CW = (LIM_MAX > 1) ? $clog2(LIM_MAX) : 1;
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic tick;

  refi_timer #(.LIM_NORMAL(LIM_N), .LIM_HOT(LIM_H), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .hot(hot_band), .tick(tick)
  );

  debt_ledger #(.MAX_DEBT(MAX_DEBT), .DW(DW)) u_ledger (
    .clk(clk), .rst_n(rst_n), .tick(tick), .grant(refresh_grant),
    .req(refresh_req), .urgent(refresh_urgent)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!refresh_req && !refresh_urgent));
endmodule

// File: tb/refresh_pacer_bench.sv
module refresh_pacer_bench;
  localparam int PER_PS = 780_000;
  localparam int LN = 7_800_000 / PER_PS;  // 10
  localparam int LH = 3_900_000 / PER_PS;  // 5
  localparam int MAXD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot_band = 1'b0;
  logic refresh_grant = 1'b0;
  logic refresh_req, refresh_urgent;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;
  int m_cnt = 0;
  int m_debt = 0;
  int lfsr = 32'h1ace;

  always #10 clk = ~clk;

  refresh_pacer #(.CLK_PERIOD_PS(PER_PS), .MAX_DEBT(MAXD)) u_refresh_pacer (
    .clk(clk), .rst_n(rst_n), .hot_band(hot_band), .refresh_grant(refresh_grant),
    .refresh_req(refresh_req), .refresh_urgent(refresh_urgent)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: owed-refresh arithmetic taken from the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_debt = 0;
    end else begin
      int lim;
      bit tk, hs;
      lim = hot_band ? LH : LN;
      tk = (m_cnt >= lim - 1);
      hs = (m_debt != 0) && refresh_grant;
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk && !hs && m_debt < MAXD) m_debt++;
      else if (hs && !tk) m_debt--;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R5 req vs owed count", int'(refresh_req), int'(m_debt != 0));
      chk("R8 urgent vs owed count", int'(refresh_urgent), int'(m_debt == MAXD));
      chk("R9 owed count bound", int'(m_debt <= MAXD), 1);
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hot_band = 1'b0; refresh_grant = 1'b0;
    repeat (3) step();
    chk("R1 req in reset", int'(refresh_req), 0);
    chk("R1 urgent in reset", int'(refresh_urgent), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int edges;
    do_reset();
    cmp_en = 1'b1;
    step();
    chk("R1 req after release", int'(refresh_req), 0);
    // R2: first request after LN edges
    edges = 1;
    while (!refresh_req && edges < 40) begin step(); edges++; end
    chk("R2 first request edge", edges, LN);
    // R8 / R9: fill the ledger without grants
    repeat (LN * MAXD) step();
    chk("R8 urgent at cap", int'(refresh_urgent), 1);
    repeat (3 * LN) step();
    chk("R9 saturated urgent", int'(refresh_urgent), 1);
    refresh_grant = 1'b1; step(); refresh_grant = 1'b0;
    chk("R8 urgent drops after one grant", int'(refresh_urgent), int'(m_debt == MAXD));
    refresh_grant = 1'b1;
    repeat (4 * LN) step();
    refresh_grant = 1'b0;

    // R3 / R4: raise hot at every offset within one normal interval
    for (int s = 0; s < LN; s++) begin
      int exp_e;
      do_reset();
      repeat (s) step();
      hot_band = 1'b1;
      edges = s;
      while (!refresh_req && edges < 40) begin step(); edges++; end
      exp_e = (s + 1 > LH) ? s + 1 : LH;
      chk($sformatf("R4 hot switch at offset %0d", s), edges, exp_e);
      step(); step();
    end
    // R3: steady hot interval between successive expiries
    do_reset();
    hot_band = 1'b1;
    repeat (LH) step();
    chk("R3 hot first request", int'(refresh_req), 1);
    refresh_grant = 1'b1; step(); refresh_grant = 1'b0;
    chk("R3 cleared after grant", int'(refresh_req), 0);
    repeat (LH - 2) step();
    chk("R3 no early hot expiry", int'(refresh_req), 0);
    step();
    chk("R3 second hot request", int'(refresh_req), 1);

    // R6: grant held high from reset, request still appears at LN
    do_reset();
    refresh_grant = 1'b1;
    repeat (LN - 1) step();
    chk("R6 grant ignored while idle", int'(refresh_req), 0);
    step();
    chk("R6 request after idle grants", int'(refresh_req), 1);
    step();
    chk("R6 request taken once", int'(refresh_req), 0);
    refresh_grant = 1'b0;

    // R7: grant in the same cycle as the second expiry
    do_reset();
    repeat (2 * LN - 1) step();
    refresh_grant = 1'b1; step(); refresh_grant = 1'b0;
    chk("R7 paired grant keeps request", int'(refresh_req), 1);
    refresh_grant = 1'b1; step(); refresh_grant = 1'b0;
    chk("R7 owed count was one", int'(refresh_req), 0);

    // Mixed sweep: pseudo-random grants and band changes
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      refresh_grant = ((lfsr & 7) < ((i / 500) % 8));
      if ((lfsr & 255) == 3) hot_band = ~hot_band;
      step();
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule